// File: doc/BRIEF.md
# Mixed-Page-Size Set-Associative TLB

This block caches virtual-to-physical translations for three page sizes (4 KB, 64 KB and 1 MB) in a single array of 64 sets by 8 ways. Every entry, whatever its size, is placed in the set selected by address bits [17:12] of the virtual address presented at fill time. The set a 4 KB page can occupy is therefore fixed, a 64 KB page can land in any of 16 neighbouring sets, and a 1 MB page can land in any set. A lookup reads one set, compares all eight ways under each way's own size mask, and returns the physical address with the in-page offset taken from the lookup address.

The page-table walker fills entries on a miss. Software-driven maintenance issues either a one-cycle global flush or per-set invalidations by address. A per-set invalidation only touches the set that address bits [17:12] select, so removing a 64 KB page takes 16 invalidations stepped by 4 KB and removing a 1 MB page takes 64. Replacement inside a set takes the lowest free way first and otherwise the least recently used way.

Top module: `mps_tlb`

## Requirements
- R1: After reset no entry is valid: every lookup misses, and `rsp_valid_o`, `hit_o` and `multi_hit_o` are low.
- R2: A lookup request in cycle N gives `rsp_valid_o`, `hit_o`, `multi_hit_o` and `pa_o` in cycle N+1. `rsp_valid_o` is low in any cycle that follows a cycle with no request.
- R3: Size code 0 (4 KB) matches on VA[31:12] and returns PA = {stored frame[31:12], VA[11:0]}.
- R4: Size code 1 (64 KB) matches on VA[31:16] and returns {stored frame[31:16], VA[15:0]}. It hits only when the lookup VA[17:12] equals the VA[17:12] used at fill.
- R5: Size code 2 (1 MB) matches on VA[31:20] and returns {stored frame[31:20], VA[19:0]}. It hits only in the set it was filled into.
- R6: When more than one way of the indexed set matches, `multi_hit_o` is 1, `hit_o` is 0 and `pa_o` is 0.
- R7: A fill writes the lowest-numbered invalid way of set VA[17:12]. If the set is full, it writes the way least recently written or returned by a single-way hit.
- R8: A global flush clears every entry in one cycle and overrides an invalidation or fill in the same cycle.
- R9: A per-address invalidation clears, in set VA[17:12] only, every valid way whose tag matches the address under that way's size mask. All other entries are kept.
- R10: A fill with size code 3 writes nothing.
- R11: Priority is global flush, then per-address invalidation, then fill; only one of them acts in a cycle. A lookup in the same cycle sees the contents from before that update and does not change the replacement order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_req_i | input | 1 | Lookup request |
| lk_va_i | input | VA_W | Lookup virtual address |
| fill_i | input | 1 | Fill request |
| fill_va_i | input | VA_W | Fill virtual address; bits [17:12] pick the set |
| fill_pa_i | input | PA_W | Fill physical frame address |
| fill_size_i | input | 2 | Page size: 0=4 KB, 1=64 KB, 2=1 MB, 3=ignored |
| inv_all_i | input | 1 | Global flush |
| inv_va_i | input | 1 | Per-set invalidation by address |
| inv_addr_i | input | VA_W | Address for the per-set invalidation |
| rsp_valid_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | Exactly one way matched |
| multi_hit_o | output | 1 | More than one way matched |
| pa_o | output | PA_W | Translated physical address, 0 unless a single hit |

## Verification
The response-timing assertion assumes `lk_req_i` is held low while reset is asserted. The replacement assertions assume way contents change only through this block's own fill and invalidate paths, which holds because all stimulus goes through the ports. The bench keeps random addresses within a few sets and a few upper address values, so sets fill up, evictions happen and overlapping page sizes create multi-hits. Requests of every kind, including same-cycle collisions, are driven half a cycle away from the sampling edge.

// File: rtl/mps_tlb_pkg.sv
package mps_tlb_pkg;
  localparam int PG_OFS  = 12;  // 4 KB offset bits
  localparam int SUB_64K = 4;   // extra offset bits of a 64 KB page
  localparam int SUB_1M  = 8;   // extra offset bits of a 1 MB page

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_RSV = 2'd3
  } pg_size_e;
endpackage

// File: rtl/mps_tlb_match.sv
module mps_tlb_match
  import mps_tlb_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int VPN_W = 20
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0][VPN_W-1:0] vtag_i,
  input  logic [WAYS-1:0][1:0]       size_i,
  input  logic [VPN_W-1:0]           vpn_i,
  output logic [WAYS-1:0]            match_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [VPN_W-1:0] mask;
    always_comb begin
      mask = '1;
      case (size_i[w])
        PG_64K:  mask[SUB_64K-1:0] = '0;
        PG_1M:   mask[SUB_1M-1:0]  = '0;
        default: ;
      endcase
    end
    assign match_o[w] = vld_i[w] && (((vtag_i[w] ^ vpn_i) & mask) == '0);
  end
endmodule

// File: rtl/mps_tlb_repl.sv
module mps_tlb_repl #(
  parameter int SETS    = 64,
  parameter int WAYS    = 8,
  parameter bit USE_LRU = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [$clog2(SETS)-1:0]  q_set_i,
  input  logic [WAYS-1:0]          q_vld_i,
  output logic [$clog2(WAYS)-1:0]  victim_o,
  input  logic                     touch_i,
  input  logic [$clog2(SETS)-1:0]  touch_set_i,
  input  logic [$clog2(WAYS)-1:0]  touch_way_i
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] free_way, old_way;

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!q_vld_i[w]) free_way = WAY_W'(w);
  end

  if (USE_LRU) begin : g_lru
    // age 0 = most recent, WAYS-1 = least recent; each set holds a permutation
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] touch_age;
    assign touch_age = age_q[touch_set_i][touch_way_i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            age_q[s][w] <= WAY_W'(w);
      end else if (touch_i) begin
        for (int w = 0; w < WAYS; w++) begin
          if (touch_way_i == WAY_W'(w))
            age_q[touch_set_i][w] <= '0;
          else if (age_q[touch_set_i][w] < touch_age)
            age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
        end
      end
    end

    always_comb begin
      old_way = '0;
      for (int w = 0; w < WAYS; w++)
        if (age_q[q_set_i][w] == WAY_W'(WAYS - 1)) old_way = WAY_W'(w);
    end

    logic [SETS-1:0] perm_ok;
    for (genvar s = 0; s < SETS; s++) begin : g_chk
      logic [WAYS-1:0] seen;
      always_comb begin
        seen = '0;
        for (int w = 0; w < WAYS; w++) seen[age_q[s][w]] = 1'b1;
      end
      assign perm_ok[s] = &seen;
    end

    p_age_perm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) &perm_ok)
      else $error("replacement ages are not a permutation");
  end else begin : g_rr
    logic [WAY_W-1:0] ptr_q [SETS];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
      end else if (touch_i && touch_way_i == ptr_q[touch_set_i]) begin
        ptr_q[touch_set_i] <= ptr_q[touch_set_i] + 1'b1;
      end
    end
    assign old_way = ptr_q[q_set_i];
  end

  assign victim_o = (&q_vld_i) ? old_way : free_way;

  p_victim_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&q_vld_i) |-> !q_vld_i[victim_o])
    else $error("victim is valid while a free way exists");
endmodule

// File: rtl/mps_tlb.sv
module mps_tlb
  import mps_tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int SETS    = 64,
  parameter int WAYS    = 8,
  parameter bit USE_LRU = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lk_req_i,
  input  logic [VA_W-1:0] lk_va_i,
  input  logic            fill_i,
  input  logic [VA_W-1:0] fill_va_i,
  input  logic [PA_W-1:0] fill_pa_i,
  input  logic [1:0]      fill_size_i,
  input  logic            inv_all_i,
  input  logic            inv_va_i,
  input  logic [VA_W-1:0] inv_addr_i,
  output logic            rsp_valid_o,
  output logic            hit_o,
  output logic            multi_hit_o,
  output logic [PA_W-1:0] pa_o
);
  localparam int VPN_W = VA_W - PG_OFS;
  localparam int PPN_W = PA_W - PG_OFS;
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic [SETS-1:0][WAYS-1:0] vld_q;
  logic [VPN_W-1:0] vtag_q [SETS][WAYS];
  logic [PPN_W-1:0] ptag_q [SETS][WAYS];
  logic [1:0]       size_q [SETS][WAYS];

  logic unused_lo;
  assign unused_lo = ^{fill_va_i[PG_OFS-1:0], fill_pa_i[PG_OFS-1:0], inv_addr_i[PG_OFS-1:0]};

  logic [IDX_W-1:0] lk_set, fill_set, iv_set;
  logic [VPN_W-1:0] lk_vpn, iv_vpn;
  assign lk_set   = lk_va_i[PG_OFS +: IDX_W];
  assign fill_set = fill_va_i[PG_OFS +: IDX_W];
  assign iv_set   = inv_addr_i[PG_OFS +: IDX_W];
  assign lk_vpn   = lk_va_i[VA_W-1:PG_OFS];
  assign iv_vpn   = inv_addr_i[VA_W-1:PG_OFS];

  logic [WAYS-1:0][VPN_W-1:0] lk_vtag, iv_vtag;
  logic [WAYS-1:0][1:0]       lk_size, iv_size;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_vtag[w] = vtag_q[lk_set][w];
      lk_size[w] = size_q[lk_set][w];
      iv_vtag[w] = vtag_q[iv_set][w];
      iv_size[w] = size_q[iv_set][w];
    end
  end

  logic [WAYS-1:0] lk_match, iv_match;

  mps_tlb_match #(.WAYS(WAYS), .VPN_W(VPN_W)) u_lk_match (
    .vld_i   (vld_q[lk_set]),
    .vtag_i  (lk_vtag),
    .size_i  (lk_size),
    .vpn_i   (lk_vpn),
    .match_o (lk_match)
  );

  mps_tlb_match #(.WAYS(WAYS), .VPN_W(VPN_W)) u_iv_match (
    .vld_i   (vld_q[iv_set]),
    .vtag_i  (iv_vtag),
    .size_i  (iv_size),
    .vpn_i   (iv_vpn),
    .match_o (iv_match)
  );

  // hit resolution
  logic [WAY_W:0]   hit_cnt;
  logic [WAY_W-1:0] hit_way;
  logic             single_hit, multi_hit;
  always_comb begin
    hit_cnt = '0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_match[w]) begin
        hit_cnt = hit_cnt + 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end
  assign single_hit = (hit_cnt == 1);
  assign multi_hit  = (hit_cnt > 1);

  logic [PPN_W-1:0] hit_ppn;
  logic [1:0]       hit_size;
  always_comb begin
    hit_ppn  = ptag_q[lk_set][hit_way];
    hit_size = size_q[lk_set][hit_way];
    case (hit_size)
      PG_64K:  hit_ppn[SUB_64K-1:0] = lk_vpn[SUB_64K-1:0];
      PG_1M:   hit_ppn[SUB_1M-1:0]  = lk_vpn[SUB_1M-1:0];
      default: ;
    endcase
  end

  // update arbitration: flush > invalidate > fill
  logic             fill_wr, lk_touch;
  logic [WAY_W-1:0] victim;
  assign fill_wr  = fill_i && (fill_size_i != PG_RSV) && !inv_all_i && !inv_va_i;
  assign lk_touch = lk_req_i && single_hit && !inv_all_i && !inv_va_i && !fill_wr;

  mps_tlb_repl #(.SETS(SETS), .WAYS(WAYS), .USE_LRU(USE_LRU)) u_repl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .q_set_i     (fill_set),
    .q_vld_i     (vld_q[fill_set]),
    .victim_o    (victim),
    .touch_i     (fill_wr || lk_touch),
    .touch_set_i (fill_wr ? fill_set : lk_set),
    .touch_way_i (fill_wr ? victim : hit_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (inv_all_i) begin
      vld_q <= '0;
    end else if (inv_va_i) begin
      vld_q[iv_set] <= vld_q[iv_set] & ~iv_match;
    end else if (fill_wr) begin
      vld_q[fill_set][victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_wr) begin
      vtag_q[fill_set][victim] <= fill_va_i[VA_W-1:PG_OFS];
      ptag_q[fill_set][victim] <= fill_pa_i[PA_W-1:PG_OFS];
      size_q[fill_set][victim] <= fill_size_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      multi_hit_o <= 1'b0;
      pa_o        <= '0;
    end else begin
      rsp_valid_o <= lk_req_i;
      hit_o       <= lk_req_i && single_hit;
      multi_hit_o <= lk_req_i && multi_hit;
      pa_o        <= (lk_req_i && single_hit) ? {hit_ppn, lk_va_i[PG_OFS-1:0]} : '0;
    end
  end

  p_rsp_timing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(lk_req_i))
    else $error("response not one cycle after request");

  p_hit_multi_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && multi_hit_o))
    else $error("hit and multi-hit together");

  p_multi_no_pa_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o |-> (pa_o == '0))
    else $error("address driven on multi-hit");

  p_flush_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> (vld_q == '0))
    else $error("entries survive a flush");

  p_inv_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_va_i && !inv_all_i) |=> ((vld_q[$past(iv_set)] & $past(iv_match)) == '0))
    else $error("matching entry survives invalidation");

  p_rsv_fill_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && fill_size_i == PG_RSV && !inv_all_i && !inv_va_i) |=> (vld_q == $past(vld_q)))
    else $error("reserved-size fill changed state");
endmodule

// File: tb/mps_tlb_bench.sv
module mps_tlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 64;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_req_i = 1'b0;
  logic [31:0] lk_va_i = '0;
  logic        fill_i = 1'b0;
  logic [31:0] fill_va_i = '0;
  logic [31:0] fill_pa_i = '0;
  logic [1:0]  fill_size_i = '0;
  logic        inv_all_i = 1'b0;
  logic        inv_va_i = 1'b0;
  logic [31:0] inv_addr_i = '0;
  logic        rsp_valid_o, hit_o, multi_hit_o;
  logic [31:0] pa_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mps_tlb u_mps_tlb (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_req_i(lk_req_i), .lk_va_i(lk_va_i),
    .fill_i(fill_i), .fill_va_i(fill_va_i), .fill_pa_i(fill_pa_i), .fill_size_i(fill_size_i),
    .inv_all_i(inv_all_i), .inv_va_i(inv_va_i), .inv_addr_i(inv_addr_i),
    .rsp_valid_o(rsp_valid_o), .hit_o(hit_o), .multi_hit_o(multi_hit_o), .pa_o(pa_o)
  );

  // reference model
  bit        m_vld  [NS][NW];
  bit [19:0] m_vtag [NS][NW];
  bit [19:0] m_ptag [NS][NW];
  bit [1:0]  m_size [NS][NW];
  int        m_ts   [NS][NW];
  int        tick = 0;

  function automatic bit m_match(int s, int w, logic [31:0] va);
    bit [19:0] mask = 20'hFFFFF;
    if (m_size[s][w] == 2'd1) mask = 20'hFFFF0;
    if (m_size[s][w] == 2'd2) mask = 20'hFFF00;
    return m_vld[s][w] && (((m_vtag[s][w] ^ va[31:12]) & mask) == 0);
  endfunction

  function automatic void model_look(input logic [31:0] va, output bit h, output bit m,
                                     output logic [31:0] pa, output int way);
    int s = int'(va[17:12]);
    int cnt = 0;
    way = 0;
    for (int w = 0; w < NW; w++)
      if (m_match(s, w, va)) begin cnt++; way = w; end
    h = (cnt == 1);
    m = (cnt > 1);
    pa = 32'h0;
    if (h) begin
      case (m_size[s][way])
        2'd1:    pa = {m_ptag[s][way][19:4], va[15:0]};
        2'd2:    pa = {m_ptag[s][way][19:8], va[19:0]};
        default: pa = {m_ptag[s][way], va[11:0]};
      endcase
    end
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic op(input bit lk, input logic [31:0] lva,
                    input bit fl, input logic [31:0] fva, input logic [31:0] fpa, input logic [1:0] fsz,
                    input bit iv, input logic [31:0] iva, input bit ia, input string req);
    bit e_hit, e_multi, fill_w;
    logic [31:0] e_pa;
    int e_way;
    model_look(lva, e_hit, e_multi, e_pa, e_way);
    lk_req_i = lk; lk_va_i = lva;
    fill_i = fl; fill_va_i = fva; fill_pa_i = fpa; fill_size_i = fsz;
    inv_va_i = iv; inv_addr_i = iva; inv_all_i = ia;
    @(negedge clk);
    if (lk) check(req, {29'h0, rsp_valid_o, hit_o, multi_hit_o, pa_o},
                  {29'h0, 1'b1, e_hit, e_multi, e_pa});
    lk_req_i = 1'b0; fill_i = 1'b0; inv_va_i = 1'b0; inv_all_i = 1'b0;
    fill_w = fl && fsz != 2'd3 && !ia && !iv;
    if (ia) begin
      for (int s = 0; s < NS; s++)
        for (int w = 0; w < NW; w++) m_vld[s][w] = 1'b0;
    end else if (iv) begin
      int s = int'(iva[17:12]);
      bit hitv [NW];
      for (int w = 0; w < NW; w++) hitv[w] = m_match(s, w, iva);
      for (int w = 0; w < NW; w++) if (hitv[w]) m_vld[s][w] = 1'b0;
    end else if (fill_w) begin
      int s = int'(fva[17:12]);
      int v = -1;
      for (int w = NW - 1; w >= 0; w--) if (!m_vld[s][w]) v = w;
      if (v < 0) begin
        v = 0;
        for (int w = 1; w < NW; w++) if (m_ts[s][w] < m_ts[s][v]) v = w;
      end
      m_vld[s][v] = 1'b1; m_vtag[s][v] = fva[31:12]; m_ptag[s][v] = fpa[31:12];
      m_size[s][v] = fsz; m_ts[s][v] = ++tick;
    end
    if (lk && e_hit && !ia && !iv && !fill_w) m_ts[int'(lva[17:12])][e_way] = ++tick;
  endtask

  task automatic lookup(input logic [31:0] va, input string req);
    op(1, va, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz, input string req);
    op(0, 0, 1, va, pa, sz, 0, 0, 0, req);
  endtask
  task automatic inval(input logic [31:0] va, input string req);
    op(0, 0, 0, 0, 0, 0, 1, va, 0, req);
  endtask

  function automatic logic [31:0] rnd_va();
    return {9'h0, 3'($urandom % 8), 2'($urandom % 4), 6'($urandom % 4), 12'($urandom)};
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog R2: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", {61'h0, rsp_valid_o, hit_o, multi_hit_o}, 64'h0);
    lookup(32'h1234_5678, "R1");
    @(negedge clk);
    check("R2", {63'h0, rsp_valid_o}, 64'h0);

    // R3: 4 KB page
    fill(32'h1234_5000, 32'hABCD_E000, 2'd0, "R3");
    lookup(32'h1234_5678, "R3");
    check("R3", {32'h0, pa_o}, {32'h0, 32'hABCD_E678});
    lookup(32'h1234_6678, "R3");

    // R4: 64 KB page placed in set 3
    fill(32'h2000_3000, 32'h7770_0000, 2'd1, "R4");
    lookup(32'h2000_3ABC, "R4");
    check("R4", {32'h0, pa_o}, {32'h0, 32'h7770_3ABC});
    lookup(32'h2000_4ABC, "R4");
    lookup(32'h2004_3ABC, "R4");

    // R5: 1 MB page placed in set 0x2B
    fill(32'h305A_B000, 32'h8000_0000, 2'd2, "R5");
    lookup(32'h305A_BFFF, "R5");
    check("R5", {32'h0, pa_o}, {32'h0, 32'h800A_BFFF});
    lookup(32'h3050_0000, "R5");

    // R6: overlapping sizes in one set, then R9 clears both
    fill(32'h4000_1000, 32'h1111_1000, 2'd0, "R6");
    fill(32'h4000_1000, 32'h2222_0000, 2'd1, "R6");
    lookup(32'h4000_1234, "R6");
    check("R6", {62'h0, hit_o, multi_hit_o}, 64'h1);
    inval(32'h4000_1000, "R9");
    lookup(32'h4000_1234, "R9");

    // R9: 64 KB page needs 16 stepped invalidations; 4 KB neighbour survives
    fill(32'h5000_7000, 32'h9990_0000, 2'd1, "R9");
    fill(32'h6000_7000, 32'h4440_7000, 2'd0, "R9");
    inval(32'h5000_0000, "R9");
    lookup(32'h5000_7010, "R9");
    for (int k = 0; k < 16; k++) inval(32'h5000_0000 + 32'(k) * 32'h1000, "R9");
    lookup(32'h5000_7010, "R9");
    check("R9", {63'h0, hit_o}, 64'h0);
    lookup(32'h6000_7010, "R9");
    check("R9", {63'h0, hit_o}, 64'h1);

    // R7: LRU within set 9
    for (int k = 0; k < 8; k++)
      fill(32'h7000_9000 + 32'(k) * 32'h0010_0000, 32'h0100_0000 + 32'(k) * 32'h1000, 2'd0, "R7");
    lookup(32'h7000_9004, "R7");
    fill(32'h7800_9000, 32'h0F00_0000, 2'd0, "R7");
    lookup(32'h7010_9004, "R7");
    check("R7", {63'h0, hit_o}, 64'h0);
    lookup(32'h7000_9004, "R7");
    inval(32'h7050_9000, "R7");
    fill(32'h7900_9000, 32'h0E00_0000, 2'd0, "R7");
    lookup(32'h7020_9004, "R7");
    check("R7", {63'h0, hit_o}, 64'h1);
    lookup(32'h7900_9004, "R7");

    // R10: reserved size ignored
    fill(32'h0AB0_2000, 32'h5550_0000, 2'd3, "R10");
    lookup(32'h0AB0_2000, "R10");
    check("R10", {63'h0, hit_o}, 64'h0);

    // R11: lookup sees old contents; invalidate beats fill
    op(1, 32'h0CC0_5000, 1, 32'h0CC0_5000, 32'h3330_5000, 2'd0, 0, 0, 0, "R11");
    check("R11", {63'h0, hit_o}, 64'h0);
    lookup(32'h0CC0_5000, "R11");
    op(0, 0, 1, 32'h0DD0_6000, 32'h3330_6000, 2'd0, 1, 32'h0CC0_5000, 0, "R11");
    lookup(32'h0DD0_6000, "R11");
    check("R11", {63'h0, hit_o}, 64'h0);

    // R8: flush beats a same-cycle fill
    op(0, 0, 1, 32'h0EE0_8000, 32'h2220_8000, 2'd0, 0, 0, 1, "R8");
    lookup(32'h0EE0_8000, "R8");
    lookup(32'h6000_7010, "R8");
    check("R8", {63'h0, hit_o}, 64'h0);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 200);
      if (r < 100)      lookup(rnd_va(), "R7");
      else if (r < 160) fill(rnd_va(), $urandom, 2'($urandom % 3), "R7");
      else if (r < 190) inval(rnd_va(), "R9");
      else if (r < 199) op(1, rnd_va(), 1, rnd_va(), $urandom, 2'($urandom % 4), 0, 0, 0, "R11");
      else              op(1, rnd_va(), 0, 0, 0, 0, 0, 0, 1, "R8");
    end

    summary();
    $finish;
  end
endmodule